// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives a host a byte-wide configuration space through two adjacent I/O addresses: an index port that selects a register and a data port, one address above it, that reads or writes the selected register. A strap input picks which of two base addresses the pair sits at. Nothing in the space can be reached until the host writes a two-byte unlock key to the index port. A single exit byte locks the space again.

Registers below a bank boundary are global and held here. They are a logical-device number register, a read-only two-byte identification value and general read/write storage. Registers at or above the boundary belong to whichever logical device the device-number register selects. For those, the block drives a one-hot bank-select vector, a register address, write data and single-cycle read and write strobes to the neighbouring device blocks. It returns the selected device's read byte to the host.

Top module: `keyed_cfg_port`

## Requirements
- R1: The index port is at address 0x2E when `strap_hi` is 0 and at 0x4E when it is 1. The data port is at the index address plus one. Writes to any other address change nothing, and reads of any other address return 0xFF.
- R2: The space unlocks only after two back-to-back index-port writes of 0x87.
- R3: Any index-port write of a value other than 0x87, made after the first key byte, sends the unlock sequence back to its start. A later unlock then needs two fresh 0x87 writes.
- R4: While unlocked, an index-port write of 0xAA locks the space.
- R5: While locked, data-port writes change no register and raise no device strobe. Reads of either port return 0xFF.
- R6: While unlocked, any other index-port write latches its value as the current index. A read of the index port returns that index.
- R7: Global register 0x07 holds the logical-device number. It is written and read through the data port.
- R8: Registers 0x20 and 0x21 read the identification value high and low byte. Its upper 12 bits are 0xA23 and its lowest 4 bits are the revision parameter (default 0x5). Writes to these registers have no effect.
- R9: The other global registers below 0x30 are read/write byte storage.
- R10: `dev_sel` has exactly bit N set when the device number N is below `NUM_DEV`, and is zero otherwise. When the index is 0x30 or above and the space is unlocked, a data-port write raises `dev_wr` for that cycle, with `dev_addr` equal to the index and `dev_wdata` equal to the written byte. A data-port read raises `dev_rd` and returns byte N of `dev_rdata`. With no device selected, no strobe is raised and reads return 0xFF.
- R11: After reset the space is locked, the index is 0x00, the device number is 0x00 and all global storage is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_hi | input | 1 | Base-address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid in the cycle `io_rd` is high, 0xFF otherwise |
| dev_sel | output | 16 | One-hot bank select from the logical-device number |
| dev_addr | output | 8 | Register number presented to the device banks |
| dev_wdata | output | 8 | Write data presented to the device banks |
| dev_wr | output | 1 | Device-register write strobe |
| dev_rd | output | 1 | Device-register read strobe |
| dev_rdata | input | 128 | Read bytes from all devices, byte N from device N |

## Verification
The hardest state to reach is the half-unlocked one. It is followed by something other than the second key byte, such as a stray address, a data-port access or an index write of another value. Each of these must restart or preserve the sequence exactly as required. The random stimulus leans toward 0x87 and 0xAA on the index port, so half-keyed states arise often and are interrupted by every kind of access. It also toggles the strap between accesses, so a key written at the wrong base is exercised. Directed sequences cover the interrupted key, the identification registers, out-of-range device numbers and data writes while locked.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  // Index-port address picked by the strap.
  function automatic logic [15:0] port_base(input logic strap,
                                            input logic [15:0] lo,
                                            input logic [15:0] hi);
    return strap ? hi : lo;
  endfunction

  // Identification value: 12-bit family code above a 4-bit revision.
  function automatic logic [15:0] make_id(input logic [11:0] family,
                                          input logic [3:0] rev);
    return {family, rev};
  endfunction

  // One-hot bank select; zero when the number is out of range.
  function automatic logic [255:0] onehot_dev(input logic [7:0] n,
                                              input int unsigned count);
    logic [255:0] v;
    v = '0;
    if (int'(n) < count) v[n] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = 8'h87,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       idx_load
);

  key_state_e state_q, state_d;

  wire enter_byte = (wdata == KEY_ENTER);
  wire exit_byte  = (wdata == KEY_EXIT);

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = enter_byte ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = enter_byte ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = exit_byte  ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
  assign idx_load = idx_wr && unlocked && !exit_byte;

  // R2: opening is only reached from the half-keyed state by a second key byte.
  p_open_needs_two_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(state_q) == KS_HALF && $past(idx_wr) && $past(wdata) == KEY_ENTER));

  // R3: an interrupting index write in the half-keyed state restarts the sequence.
  p_restart_on_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && idx_wr && !enter_byte) |=> (state_q == KS_LOCKED));

  // R4: the exit byte locks an open space.
  p_exit_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && exit_byte) |=> !unlocked);

endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
  import cfgp_pkg::*;
#(
  parameter int unsigned BANK_START = 48,
  parameter logic [7:0]  LDN_REG    = 8'h07,
  parameter logic [7:0]  ID_HI_REG  = 8'h20,
  parameter logic [7:0]  ID_LO_REG  = 8'h21,
  parameter logic [15:0] ID_VALUE   = 16'hA235
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rdata
);

  localparam int unsigned GW = $clog2(BANK_START);

  logic [7:0]    store_q [BANK_START];
  logic [7:0]    ldn_q;
  logic [GW-1:0] slot;

  assign slot = idx[GW-1:0];

  wire in_range = (int'(idx) < BANK_START);
  wire ldn_we   = wr && (idx == LDN_REG);
  wire id_hit   = (idx == ID_HI_REG) || (idx == ID_LO_REG);
  wire store_we = wr && in_range && !id_hit && (idx != LDN_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldn_q <= '0;
    else if (ldn_we) ldn_q <= wdata;
  end

  for (genvar g = 0; g < BANK_START; g++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store_q[g] <= '0;
      else if (store_we && slot == GW'(g)) store_q[g] <= wdata;
    end
  end

  always_comb begin
    if (idx == LDN_REG)        rdata = ldn_q;
    else if (idx == ID_HI_REG) rdata = ID_VALUE[15:8];
    else if (idx == ID_LO_REG) rdata = ID_VALUE[7:0];
    else if (in_range)         rdata = store_q[slot];
    else                       rdata = 8'hFF;
  end

  assign ldn = ldn_q;

  // R7: the device number moves only on a write aimed at its register.
  p_ldn_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ldn_we |=> $stable(ldn_q));

endmodule

// File: rtl/cfgp_bank_dec.sv
module cfgp_bank_dec
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_DEV = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           ldn,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic [NUM_DEV*8-1:0] rdata_all,
  output logic [NUM_DEV-1:0]   sel,
  output logic                 wr_stb,
  output logic                 rd_stb,
  output logic [7:0]           rdata
);

  logic [255:0] sel_full;
  assign sel_full = onehot_dev(ldn, NUM_DEV);
  assign sel      = sel_full[NUM_DEV-1:0];

  wire any_sel = |sel;
  assign wr_stb = acc_wr && any_sel;
  assign rd_stb = acc_rd && any_sel;

  always_comb begin
    rdata = 8'hFF;
    for (int d = 0; d < NUM_DEV; d++)
      if (sel[d]) rdata = rdata_all[d*8 +: 8];
  end

  // R10: at most one bank selected, and strobes only go to a selected bank.
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  p_strobe_has_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |-> ($countones(sel) == 1));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_DEV    = 16,
  parameter int unsigned BANK_START = 48,
  parameter logic [15:0] BASE_LO    = 16'h002E,
  parameter logic [15:0] BASE_HI    = 16'h004E,
  parameter logic [11:0] ID_FAMILY  = 12'hA23,
  parameter logic [3:0]  ID_REV     = 4'h5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_hi,
  input  logic [15:0]          io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic [NUM_DEV-1:0]   dev_sel,
  output logic [7:0]           dev_addr,
  output logic [7:0]           dev_wdata,
  output logic                 dev_wr,
  output logic                 dev_rd,
  input  logic [NUM_DEV*8-1:0] dev_rdata
);

  localparam logic [15:0] ID_VALUE = make_id(ID_FAMILY, ID_REV);

  logic [15:0] base;
  logic        unlocked, idx_load;
  logic [7:0]  idx_q, ldn, glb_rdata, bank_rdata;

  assign base = port_base(strap_hi, BASE_LO, BASE_HI);

  wire hit_idx  = (io_addr == base);
  wire hit_dat  = (io_addr == base + 16'd1);
  wire idx_wr   = io_wr && hit_idx;
  wire dat_wr   = io_wr && hit_dat && unlocked;
  wire dat_rd   = io_rd && !io_wr && hit_dat && unlocked;
  wire banked   = (int'(idx_q) >= BANK_START);

  cfgp_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .unlocked (unlocked),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (idx_load) idx_q <= io_wdata;
  end

  cfgp_global_regs #(
    .BANK_START (BANK_START),
    .ID_VALUE   (ID_VALUE)
  ) u_glb (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (dat_wr && !banked),
    .idx   (idx_q),
    .wdata (io_wdata),
    .ldn   (ldn),
    .rdata (glb_rdata)
  );

  cfgp_bank_dec #(
    .NUM_DEV (NUM_DEV)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ldn       (ldn),
    .acc_wr    (dat_wr && banked),
    .acc_rd    (dat_rd && banked),
    .rdata_all (dev_rdata),
    .sel       (dev_sel),
    .wr_stb    (dev_wr),
    .rd_stb    (dev_rd),
    .rdata     (bank_rdata)
  );

  assign dev_addr  = idx_q;
  assign dev_wdata = io_wdata;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && unlocked) begin
      if (hit_idx)      io_rdata = idx_q;
      else if (hit_dat) io_rdata = banked ? bank_rdata : glb_rdata;
    end
  end

  // R5: a locked space raises no device strobe.
  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!dev_wr && !dev_rd));

  // R6: the index only moves on an index-port write.
  p_idx_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));

  // R10: device strobes only for banked indices.
  p_strobe_banked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (int'(dev_addr) >= BANK_START));

endmodule

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;

  localparam int CLK_P = 10;
  localparam int NDEV  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            strap_hi = 1'b0;
  logic [15:0]     io_addr = '0;
  logic            io_wr = 1'b0;
  logic            io_rd = 1'b0;
  logic [7:0]      io_wdata = '0;
  logic [7:0]      io_rdata;
  logic [NDEV-1:0] dev_sel;
  logic [7:0]      dev_addr, dev_wdata;
  logic            dev_wr, dev_rd;
  logic [NDEV*8-1:0] dev_rdata;

  int checks = 0;
  int errors = 0;

  // bench model: 0 locked, 1 half, 2 open
  int         m_st = 0;
  logic [7:0] m_idx = 0;
  logic [7:0] m_ldn = 0;
  logic [7:0] m_glb [48];

  always #(CLK_P/2) clk = ~clk;

  keyed_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_sel(dev_sel), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] dev_byte(int d);
    return 8'((d * 37 + 27) & 255);
  endfunction

  function automatic logic [15:0] ixp();
    return strap_hi ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [NDEV-1:0] exp_sel();
    logic [NDEV-1:0] v = '0;
    if (m_ldn < NDEV) v[m_ldn[3:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_glb(logic [7:0] i);
    if (i == 8'h07) return m_ldn;
    if (i == 8'h20) return 8'hA2;
    if (i == 8'h21) return 8'h35;
    return m_glb[i[5:0]];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic op_wr(logic [15:0] a, logic [7:0] d);
    logic bankw;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1;
    bankw = (m_st == 2) && (a == ixp() + 16'd1) && (m_idx >= 8'h30) && (m_ldn < NDEV);
    chk(m_st == 2 ? "R10" : "R5", {31'd0, dev_wr}, {31'd0, bankw});
    chk("R10", {16'd0, dev_sel}, {16'd0, exp_sel()});
    if (bankw) begin
      chk("R10", {24'd0, dev_addr}, {24'd0, m_idx});
      chk("R10", {24'd0, dev_wdata}, {24'd0, d});
    end
    @(posedge clk);
    #1 io_wr = 1'b0;
    if (a == ixp()) begin
      case (m_st)
        0: m_st = (d == 8'h87) ? 1 : 0;
        1: m_st = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) m_st = 0; else m_idx = d;
      endcase
    end else if (a == ixp() + 16'd1 && m_st == 2 && m_idx < 8'h30) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx != 8'h20 && m_idx != 8'h21) m_glb[m_idx[5:0]] = d;
    end
  endtask

  task automatic op_rd(logic [15:0] a, string tag);
    logic [7:0] e;
    string r;
    logic bankr;
    bankr = 1'b0;
    if (a != ixp() && a != ixp() + 16'd1) begin e = 8'hFF; r = "R1"; end
    else if (m_st != 2) begin e = 8'hFF; r = "R5"; end
    else if (a == ixp()) begin e = m_idx; r = "R6"; end
    else if (m_idx >= 8'h30) begin
      bankr = (m_ldn < NDEV);
      e = bankr ? dev_byte(int'(m_ldn)) : 8'hFF; r = "R10";
    end else begin
      e = exp_glb(m_idx);
      r = (m_idx == 8'h07) ? "R7" : (m_idx == 8'h20 || m_idx == 8'h21) ? "R8" : "R9";
    end
    if (tag != "") r = tag;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(r, {24'd0, io_rdata}, {24'd0, e});
    chk(r, {31'd0, dev_rd}, {31'd0, bankr});
    @(posedge clk);
    #1 io_rd = 1'b0;
  endtask

  task automatic unlock();
    op_wr(ixp(), 8'h87);
    op_wr(ixp(), 8'h87);
  endtask

  task automatic set_reg(logic [7:0] r, logic [7:0] d);
    op_wr(ixp(), r);
    op_wr(ixp() + 16'd1, d);
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++) dev_rdata[d*8 +: 8] = dev_byte(d);
    for (int i = 0; i < 48; i++) m_glb[i] = 8'h00;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] a;
    int          sel;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: locked after reset, then index and device number read zero
    op_rd(16'h002E, "R11");
    unlock();
    op_rd(16'h002E, "R11");
    op_wr(16'h002E, 8'h07);
    op_rd(16'h002F, "R11");
    op_wr(16'h002E, 8'h25);
    op_rd(16'h002F, "R11");

    // R8: identification value, writes ignored
    set_reg(8'h20, 8'h00);
    op_rd(16'h002F, "R8");
    set_reg(8'h21, 8'hFF);
    op_rd(16'h002F, "R8");

    // R9 / R7 storage
    set_reg(8'h2B, 8'h5C);
    op_rd(16'h002F, "R9");
    set_reg(8'h07, 8'h03);
    op_rd(16'h002F, "R7");

    // R10: bank access for device 3, then an out-of-range device
    set_reg(8'h30, 8'h9E);
    op_rd(16'h002F, "R10");
    set_reg(8'h07, 8'd20);
    op_wr(16'h002E, 8'hF1);
    op_wr(16'h002F, 8'h11);
    op_rd(16'h002F, "R10");

    // R4: exit byte locks; R5: data write while locked ignored
    op_wr(16'h002E, 8'h2B);
    op_wr(16'h002E, 8'hAA);
    op_rd(16'h002E, "R4");
    op_wr(16'h002F, 8'hEE);
    unlock();
    op_rd(16'h002F, "R5");

    // R3: interrupted key does not unlock
    op_wr(16'h002E, 8'hAA);
    op_wr(16'h002E, 8'h87);
    op_wr(16'h002E, 8'h12);
    op_wr(16'h002E, 8'h87);
    op_rd(16'h002E, "R3");
    op_wr(16'h002E, 8'h87);
    op_rd(16'h002E, "R2");

    // R1: high base by strap, low base no longer answers
    op_wr(16'h002E, 8'hAA);
    strap_hi = 1'b1;
    op_wr(16'h002E, 8'h87);
    op_wr(16'h002E, 8'h87);
    op_rd(16'h004E, "R1");
    unlock();
    op_rd(16'h004E, "R1");
    op_rd(16'h002E, "R1");

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 40) == 0) strap_hi = ~strap_hi;
      sel = $urandom_range(0, 9);
      v = 8'($urandom);
      case (sel)
        0, 1: op_wr(ixp(), 8'h87);
        2:    op_wr(ixp(), ($urandom_range(0, 3) == 0) ? 8'hAA : v);
        3:    op_wr(ixp(), ($urandom_range(0, 1) == 0) ? 8'h07 : 8'(8'h1C + $urandom_range(0, 40)));
        4:    op_wr(ixp() + 16'd1, (m_idx == 8'h07) ? 8'($urandom_range(0, 20)) : v);
        5, 6: op_rd(ixp() + 16'd1, "");
        7:    op_rd(ixp(), "");
        default: begin
          a = 16'($urandom_range(16'h0020, 16'h0060));
          if (a == ixp() || a == ixp() + 16'd1) a = 16'h0100;
          if (sel == 8) op_wr(a, v); else op_rd(a, "R1");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule